// File: doc/BRIEF.md
# SPI Transmit/Receive FIFO Pair with DMA Request Logic

This block sits between a register bus and a serial shift engine. It buffers outgoing words in a transmit queue, which the bus fills and the engine drains, and incoming words in a receive queue, which the engine fills and the bus drains. Both queues are first-in first-out and show their oldest entry on the data output. Each queue reports how many entries it holds, and the block combines those counts with an engine busy input into a five-bit status vector.

Software sets one watermark per direction through a write-filtered threshold register. A threshold write is kept only when the value is below the queue depth, so software can find the depth by writing rising values and reading them back. Each direction also has its own DMA request level and DMA enable bit. The request for that direction follows its level and drops for one cycle after every acknowledge. Dropping the global enable discards the contents of both queues.

Top module: `spi_fifo_pair`

## Requirements
- R1: Each level output equals the number of stored entries. An accepted push raises it by one and an accepted pop lowers it by one, both one cycle later. A push and a pop in the same cycle leave it unchanged.
- R2: Each queue returns words in the order they were accepted, and the oldest stored word is always present on its data output.
- R3: A push into a full queue (level = DEPTH) is dropped and leaves the contents unchanged. A pop from an empty queue is ignored and the level stays 0.
- R4: The status output holds engine busy at bit 0, transmit full at bit 1, transmit empty at bit 2, receive empty at bit 3 and receive full at bit 4. Busy passes straight through from busy_i.
- R5: A threshold write is stored only when the written value is below DEPTH. Any other write leaves the previous value in place. Both thresholds reset to 0.
- R6: tx_wm_o is high while the transmit level is at or below the transmit threshold. rx_wm_o is high while the receive level is strictly above the receive threshold.
- R7: tx_dma_req_o is high when enable_i is high, dma_ctrl_i bit 1 is high and the transmit level is at or below tx_dma_lvl_i. It is low otherwise, apart from the masking in R9.
- R8: rx_dma_req_o is high when enable_i is high, dma_ctrl_i bit 0 is high and the receive level is strictly above rx_dma_lvl_i. It is low otherwise, apart from the masking in R9.
- R9: In the cycle that follows an acknowledge on a direction, that direction's DMA request is low. After that it follows R7 or R8 again.
- R10: While enable_i is low, both queues read empty from the next cycle on and all pushes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Global enable; low flushes both queues |
| busy_i | input | 1 | Shift engine busy, reported in status bit 0 |
| tx_push_i | input | 1 | Bus writes a word into the transmit queue |
| tx_data_i | input | WIDTH | Word to transmit |
| tx_pop_i | input | 1 | Engine takes the head transmit word |
| tx_data_o | output | WIDTH | Head of the transmit queue |
| rx_push_i | input | 1 | Engine stores a received word |
| rx_data_i | input | WIDTH | Received word |
| rx_pop_i | input | 1 | Bus reads the head receive word |
| rx_data_o | output | WIDTH | Head of the receive queue |
| tx_lvl_o | output | LVL_W | Transmit entry count |
| rx_lvl_o | output | LVL_W | Receive entry count |
| status_o | output | 5 | {rx full, rx empty, tx empty, tx full, busy} |
| tx_thr_we_i | input | 1 | Transmit threshold write strobe |
| tx_thr_wdata_i | input | THR_W | Transmit threshold write value |
| tx_thr_o | output | THR_W | Stored transmit threshold |
| rx_thr_we_i | input | 1 | Receive threshold write strobe |
| rx_thr_wdata_i | input | THR_W | Receive threshold write value |
| rx_thr_o | output | THR_W | Stored receive threshold |
| tx_wm_o | output | 1 | Transmit level at or below its threshold |
| rx_wm_o | output | 1 | Receive level above its threshold |
| dma_ctrl_i | input | 2 | Bit 0 enables receive DMA, bit 1 enables transmit DMA |
| tx_dma_lvl_i | input | LVL_W | Transmit DMA request level |
| rx_dma_lvl_i | input | LVL_W | Receive DMA request level |
| tx_dma_ack_i | input | 1 | Transmit DMA acknowledge |
| rx_dma_ack_i | input | 1 | Receive DMA acknowledge |
| tx_dma_req_o | output | 1 | Transmit DMA request |
| rx_dma_req_o | output | 1 | Receive DMA request |

## Verification
The hardest state to reach from the ports is a queue that is exactly full while further pushes keep arriving. The stimulus fills each queue one word at a time up to DEPTH and pushes once more. The scoreboard then has to show that the extra word never comes out and that the words before it keep their order. The same stimulus is used for a push and a pop in the same cycle, for a level sitting exactly on a threshold or DMA level, and for a flush taken while both queues hold data, so each comparison is seen at its boundary.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int ST_BUSY     = 0;
  localparam int ST_TX_FULL  = 1;
  localparam int ST_TX_EMPTY = 2;
  localparam int ST_RX_EMPTY = 3;
  localparam int ST_RX_FULL  = 4;
  localparam int ST_W        = 5;

  localparam int DMA_RX_EN = 0;
  localparam int DMA_TX_EN = 1;

  typedef struct packed {
    logic rx_full;
    logic rx_empty;
    logic tx_empty;
    logic tx_full;
    logic busy;
  } status_t;
endpackage

// File: rtl/sfp_fifo.sv
module sfp_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic [LVL_W-1:0] level_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0]  mem_q [DEPTH];
  logic [ADDR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0]  cnt_q;
  logic              push_ok, pop_ok;

  function automatic logic [ADDR_W-1:0] ptr_next(input logic [ADDR_W-1:0] p);
    return (p == ADDR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == LVL_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i & ~full_o & ~flush_i;
  assign pop_ok  = pop_i & ~empty_o & ~flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= data_i;
  end

  assign data_o  = mem_q[rd_ptr_q];
  assign level_o = cnt_q;

  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LVL_W'(DEPTH)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> (level_o == LVL_W'(DEPTH))); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i && !flush_i) |=> empty_o); // R3
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o); // R10
endmodule

// File: rtl/sfp_thresh.sv
module sfp_thresh #(
  parameter int THR_W = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [THR_W-1:0] wdata_i,
  output logic [THR_W-1:0] thr_o
);
  localparam logic [THR_W:0] LIMIT = (THR_W + 1)'(DEPTH);

  logic [THR_W-1:0] thr_q;
  logic             in_range;

  assign in_range = ({1'b0, wdata_i} < LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                thr_q <= '0;
    else if (we_i && in_range)  thr_q <= wdata_i;
  end

  assign thr_o = thr_q;

  AST_THR_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ({1'b0, wdata_i} >= LIMIT)) |=> $stable(thr_o)); // R5
  AST_THR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, thr_o} < LIMIT)); // R5
endmodule

// File: rtl/sfp_level_cmp.sv
module sfp_level_cmp #(
  parameter int W     = 5,
  parameter bit ABOVE = 1'b0
) (
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] mark_i,
  output logic         hit_o
);
  generate
    if (ABOVE) begin : g_above
      assign hit_o = (level_i > mark_i);
    end else begin : g_at_or_below
      assign hit_o = (level_i <= mark_i);
    end
  endgenerate
endmodule

// File: rtl/sfp_dma_req.sv
module sfp_dma_req #(
  parameter int W     = 5,
  parameter bit ABOVE = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] mark_i,
  input  logic         ack_i,
  output logic         req_o
);
  logic hit, hold_q;

  sfp_level_cmp #(.W(W), .ABOVE(ABOVE)) i_cmp (
    .level_i (level_i),
    .mark_i  (mark_i),
    .hit_o   (hit)
  );

  // one idle cycle after each acknowledge so the requester sees the new level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else         hold_q <= ack_i;
  end

  assign req_o = en_i & hit & ~hold_q;

  AST_ACK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !req_o); // R9
endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
  import spi_fifo_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  parameter int THR_W = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             busy_i,
  input  logic             tx_push_i,
  input  logic [WIDTH-1:0] tx_data_i,
  input  logic             tx_pop_i,
  output logic [WIDTH-1:0] tx_data_o,
  input  logic             rx_push_i,
  input  logic [WIDTH-1:0] rx_data_i,
  input  logic             rx_pop_i,
  output logic [WIDTH-1:0] rx_data_o,
  output logic [LVL_W-1:0] tx_lvl_o,
  output logic [LVL_W-1:0] rx_lvl_o,
  output logic [ST_W-1:0]  status_o,
  input  logic             tx_thr_we_i,
  input  logic [THR_W-1:0] tx_thr_wdata_i,
  output logic [THR_W-1:0] tx_thr_o,
  input  logic             rx_thr_we_i,
  input  logic [THR_W-1:0] rx_thr_wdata_i,
  output logic [THR_W-1:0] rx_thr_o,
  output logic             tx_wm_o,
  output logic             rx_wm_o,
  input  logic [1:0]       dma_ctrl_i,
  input  logic [LVL_W-1:0] tx_dma_lvl_i,
  input  logic [LVL_W-1:0] rx_dma_lvl_i,
  input  logic             tx_dma_ack_i,
  input  logic             rx_dma_ack_i,
  output logic             tx_dma_req_o,
  output logic             rx_dma_req_o
);
  localparam int CMP_W = (THR_W > LVL_W) ? THR_W : LVL_W;

  logic    flush;
  logic    tx_full, tx_empty, rx_full, rx_empty;
  status_t st;

  assign flush = ~enable_i;

  sfp_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_tx_fifo (
    .clk_i, .rst_ni, .flush_i(flush),
    .push_i(tx_push_i), .data_i(tx_data_i), .pop_i(tx_pop_i), .data_o(tx_data_o),
    .level_o(tx_lvl_o), .full_o(tx_full), .empty_o(tx_empty)
  );

  sfp_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_rx_fifo (
    .clk_i, .rst_ni, .flush_i(flush),
    .push_i(rx_push_i), .data_i(rx_data_i), .pop_i(rx_pop_i), .data_o(rx_data_o),
    .level_o(rx_lvl_o), .full_o(rx_full), .empty_o(rx_empty)
  );

  sfp_thresh #(.THR_W(THR_W), .DEPTH(DEPTH)) i_tx_thr (
    .clk_i, .rst_ni, .we_i(tx_thr_we_i), .wdata_i(tx_thr_wdata_i), .thr_o(tx_thr_o)
  );

  sfp_thresh #(.THR_W(THR_W), .DEPTH(DEPTH)) i_rx_thr (
    .clk_i, .rst_ni, .we_i(rx_thr_we_i), .wdata_i(rx_thr_wdata_i), .thr_o(rx_thr_o)
  );

  sfp_level_cmp #(.W(CMP_W), .ABOVE(1'b0)) i_tx_wm (
    .level_i(CMP_W'(tx_lvl_o)), .mark_i(CMP_W'(tx_thr_o)), .hit_o(tx_wm_o)
  );

  sfp_level_cmp #(.W(CMP_W), .ABOVE(1'b1)) i_rx_wm (
    .level_i(CMP_W'(rx_lvl_o)), .mark_i(CMP_W'(rx_thr_o)), .hit_o(rx_wm_o)
  );

  sfp_dma_req #(.W(LVL_W), .ABOVE(1'b0)) i_tx_dma (
    .clk_i, .rst_ni, .en_i(enable_i & dma_ctrl_i[DMA_TX_EN]),
    .level_i(tx_lvl_o), .mark_i(tx_dma_lvl_i), .ack_i(tx_dma_ack_i), .req_o(tx_dma_req_o)
  );

  sfp_dma_req #(.W(LVL_W), .ABOVE(1'b1)) i_rx_dma (
    .clk_i, .rst_ni, .en_i(enable_i & dma_ctrl_i[DMA_RX_EN]),
    .level_i(rx_lvl_o), .mark_i(rx_dma_lvl_i), .ack_i(rx_dma_ack_i), .req_o(rx_dma_req_o)
  );

  always_comb begin
    st.busy     = busy_i;
    st.tx_full  = tx_full;
    st.tx_empty = tx_empty;
    st.rx_empty = rx_empty;
    st.rx_full  = rx_full;
  end
  assign status_o = st;

  AST_TX_REQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(enable_i && dma_ctrl_i[DMA_TX_EN]) |-> !tx_dma_req_o); // R7
  AST_RX_REQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(enable_i && dma_ctrl_i[DMA_RX_EN]) |-> !rx_dma_req_o); // R8
  AST_DISABLE_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (tx_lvl_o == '0 && rx_lvl_o == '0)); // R10
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_o[ST_TX_FULL] && status_o[ST_TX_EMPTY]) && !(status_o[ST_RX_FULL] && status_o[ST_RX_EMPTY])); // R4
endmodule

// File: tb/test_spi_fifo_pair.sv
`timescale 1ns/1ps
module test_spi_fifo_pair;
  localparam int CLK_PERIOD = 10;
  localparam int WIDTH = 16;
  localparam int DEPTH = 16;
  localparam int THR_W = 8;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk_i = 1'b0, rst_ni = 1'b0, enable_i = 1'b1, busy_i = 1'b0;
  logic tx_push_i = 0, tx_pop_i = 0, rx_push_i = 0, rx_pop_i = 0;
  logic [WIDTH-1:0] tx_data_i = '0, rx_data_i = '0, tx_data_o, rx_data_o;
  logic [LVL_W-1:0] tx_lvl_o, rx_lvl_o, tx_dma_lvl_i = '0, rx_dma_lvl_i = '0;
  logic [4:0] status_o;
  logic tx_thr_we_i = 0, rx_thr_we_i = 0;
  logic [THR_W-1:0] tx_thr_wdata_i = '0, rx_thr_wdata_i = '0, tx_thr_o, rx_thr_o;
  logic tx_wm_o, rx_wm_o, tx_dma_ack_i = 0, rx_dma_ack_i = 0, tx_dma_req_o, rx_dma_req_o;
  logic [1:0] dma_ctrl_i = 2'b00;

  int n_chk = 0, n_fail = 0;
  int tx_q[$], rx_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  spi_fifo_pair #(.WIDTH(WIDTH), .DEPTH(DEPTH), .THR_W(THR_W)) i_spi_fifo_pair (.*);

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  // driver: issue transfers and record what the queues must return
  task automatic tx_push(int d);
    tx_push_i = 1'b1; tx_data_i = WIDTH'(d);
    if (enable_i && tx_lvl_o < LVL_W'(DEPTH)) tx_q.push_back(d & 16'hffff);
    tick(); tx_push_i = 1'b0;
  endtask
  task automatic tx_pop();
    tx_pop_i = 1'b1; tick(); tx_pop_i = 1'b0;
  endtask
  task automatic rx_push(int d);
    rx_push_i = 1'b1; rx_data_i = WIDTH'(d);
    if (enable_i && rx_lvl_o < LVL_W'(DEPTH)) rx_q.push_back(d & 16'hffff);
    tick(); rx_push_i = 1'b0;
  endtask
  task automatic rx_pop();
    rx_pop_i = 1'b1; tick(); rx_pop_i = 1'b0;
  endtask
  task automatic drain_all();
    while (tx_lvl_o != 0) tx_pop();
    while (rx_lvl_o != 0) rx_pop();
  endtask

  // monitor: compare each word leaving a queue with the scoreboard (R2)
  always @(negedge clk_i) begin
    if (rst_ni && enable_i && tx_pop_i && !status_o[2]) begin
      if (tx_q.size() == 0) check("R2 tx unexpected word", int'(tx_data_o), -1);
      else check("R2 tx order", int'(tx_data_o), tx_q.pop_front());
    end
    if (rst_ni && enable_i && rx_pop_i && !status_o[3]) begin
      if (rx_q.size() == 0) check("R2 rx unexpected word", int'(rx_data_o), -1);
      else check("R2 rx order", int'(rx_data_o), rx_q.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    // reset state
    check("R1 reset tx level", tx_lvl_o, 0);
    check("R1 reset rx level", rx_lvl_o, 0);
    check("R4 reset status", status_o, 5'b01100);
    check("R5 reset tx thr", tx_thr_o, 0);
    check("R5 reset rx thr", rx_thr_o, 0);
    check("R6 reset tx wm", tx_wm_o, 1);
    check("R6 reset rx wm", rx_wm_o, 0);
    check("R7 reset tx req", tx_dma_req_o, 0);
    check("R8 reset rx req", rx_dma_req_o, 0);

    // R1 / R4: few words
    tx_push(16'h11); tx_push(16'h22); tx_push(16'h33);
    check("R1 tx level 3", tx_lvl_o, 3);
    check("R4 tx not empty", status_o, 5'b01000);
    check("R2 tx head", tx_data_o, 16'h11);
    repeat (3) tx_pop();
    check("R1 tx level back to 0", tx_lvl_o, 0);

    // R3: fill to full, overflow push dropped
    for (int i = 0; i < DEPTH; i++) tx_push(100 + 3 * i);
    check("R1 tx level full", tx_lvl_o, DEPTH);
    check("R4 tx full flag", status_o, 5'b01010);
    tx_push(16'hdead);
    check("R3 overflow level held", tx_lvl_o, DEPTH);
    check("R3 head after overflow", tx_data_o, 100);
    repeat (DEPTH) tx_pop();
    check("R1 tx drained", tx_lvl_o, 0);
    tx_pop(); tx_pop();
    check("R3 underflow level held", tx_lvl_o, 0);

    // receive side, push+pop same cycle
    for (int i = 0; i < 5; i++) rx_push(16'h500 + i);
    check("R1 rx level 5", rx_lvl_o, 5);
    rx_push_i = 1'b1; rx_pop_i = 1'b1; rx_data_i = 16'h5aa;
    rx_q.push_back(16'h5aa);
    tick(); rx_push_i = 1'b0; rx_pop_i = 1'b0;
    check("R1 rx push+pop level", rx_lvl_o, 5);
    for (int i = 0; i < DEPTH; i++) rx_push(16'h700 + i);
    check("R4 rx full flag", status_o, 5'b10100);
    check("R3 rx level capped", rx_lvl_o, DEPTH);
    while (rx_lvl_o != 0) rx_pop();
    check("R4 rx empty again", status_o, 5'b01100);

    // R4 busy
    busy_i = 1'b1; tick();
    check("R4 busy bit", status_o, 5'b01101);
    busy_i = 1'b0; tick();

    // R5 thresholds
    tx_thr_we_i = 1; tx_thr_wdata_i = 5; tick(); tx_thr_we_i = 0;
    check("R5 tx thr 5", tx_thr_o, 5);
    tx_thr_we_i = 1; tx_thr_wdata_i = DEPTH; tick(); tx_thr_we_i = 0;
    check("R5 tx thr DEPTH rejected", tx_thr_o, 5);
    tx_thr_we_i = 1; tx_thr_wdata_i = 200; tick(); tx_thr_we_i = 0;
    check("R5 tx thr 200 rejected", tx_thr_o, 5);
    tx_thr_we_i = 1; tx_thr_wdata_i = DEPTH - 1; tick(); tx_thr_we_i = 0;
    check("R5 tx thr DEPTH-1", tx_thr_o, DEPTH - 1);
    rx_thr_we_i = 1; rx_thr_wdata_i = 3; tick(); rx_thr_we_i = 0;
    check("R5 rx thr 3", rx_thr_o, 3);

    // R6 watermarks
    tx_thr_we_i = 1; tx_thr_wdata_i = 2; tick(); tx_thr_we_i = 0;
    repeat (3) tx_push(16'h900);
    check("R6 tx wm above", tx_wm_o, 0);
    tx_pop();
    check("R6 tx wm at mark", tx_wm_o, 1);
    repeat (3) rx_push(16'ha00);
    check("R6 rx wm at mark", rx_wm_o, 0);
    rx_push(16'ha01);
    check("R6 rx wm above", rx_wm_o, 1);
    drain_all();

    // R7 / R8 DMA requests
    dma_ctrl_i = 2'b10; tx_dma_lvl_i = 2; rx_dma_lvl_i = 1; tick();
    check("R7 tx req empty", tx_dma_req_o, 1);
    check("R8 rx req disabled", rx_dma_req_o, 0);
    repeat (3) tx_push(16'hb00);
    check("R7 tx req above", tx_dma_req_o, 0);
    tx_pop();
    check("R7 tx req at level", tx_dma_req_o, 1);
    drain_all();
    dma_ctrl_i = 2'b01; tick();
    check("R8 rx req empty", rx_dma_req_o, 0);
    check("R7 tx req disabled", tx_dma_req_o, 0);
    repeat (2) rx_push(16'hc00);
    check("R8 rx req above", rx_dma_req_o, 1);
    rx_pop();
    check("R8 rx req at level", rx_dma_req_o, 0);
    drain_all();

    // R9 acknowledge gap
    dma_ctrl_i = 2'b10; tick();
    tx_dma_ack_i = 1'b1; tick(); tx_dma_ack_i = 1'b0;
    check("R9 tx req masked after ack", tx_dma_req_o, 0);
    tick();
    check("R9 tx req restored", tx_dma_req_o, 1);
    dma_ctrl_i = 2'b01; repeat (2) rx_push(16'hd00);
    rx_dma_ack_i = 1'b1; tick(); rx_dma_ack_i = 1'b0;
    check("R9 rx req masked after ack", rx_dma_req_o, 0);
    tick();
    check("R9 rx req restored", rx_dma_req_o, 1);
    drain_all();

    // R10 global enable flush
    dma_ctrl_i = 2'b10;
    repeat (4) tx_push(16'he00);
    repeat (4) rx_push(16'hf00);
    enable_i = 1'b0; tick();
    tx_q.delete(); rx_q.delete();
    check("R10 tx flushed", tx_lvl_o, 0);
    check("R10 rx flushed", rx_lvl_o, 0);
    check("R10 status empty", status_o, 5'b01100);
    check("R7 tx req off while disabled", tx_dma_req_o, 0);
    tx_push(16'h1234);
    check("R10 push ignored", tx_lvl_o, 0);
    enable_i = 1'b1; dma_ctrl_i = 2'b00; tick();
    tx_push(16'h4321);
    check("R10 resumes after enable", tx_lvl_o, 1);
    check("R2 head after flush", tx_data_o, 16'h4321);
    tx_pop();
    tick();
    check("R2 scoreboard empty", tx_q.size() + rx_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule